// File: doc/BRIEF.md
# Exception Entry Sequencer

This block sits next to a small 32-bit processor core and carries out the bus work needed to enter exception handling. There are two reset-style entries: power-on and manual. For these it reads a starting program counter and stack pointer from a fixed pair of words. It then hands back a cleared vector base and a status word with the interrupt mask raised to its maximum.

For the other entries the block saves the core's status word and program counter below the current stack pointer, then reads the handler address from the vector table. The other entries are address errors, accepted interrupts, trap instructions, and undefined opcodes in ordinary or delay-slot position. The core supplies its live PC, SR, R15 and VBR. The block returns the new values together with a one-cycle load strobe.

All memory traffic goes through one synchronous request/ready port. Requests that arrive together are served by fixed priority. A busy indication covers the whole sequence.

Top module: `exc_entry_seq`

## Requirements
- R1: A rising edge on `pwr_rst_n`, or a one-cycle pulse on `wdt_pwr_ovf`, starts a power-on entry. It reads the new PC from byte address 0x00000000 and the new SP from byte address 0x00000004.
- R2: A rising edge on `man_rst_n`, or a pulse on `wdt_man_ovf`, starts a manual entry. It reads the new PC from 0x00000008 and the new SP from 0x0000000C.
- R3: At the end of either reset entry, `new_vbr` is 0 and `new_sr` is 0x000000F0. The interrupt mask is the 4-bit field SR[7:4], so this value is that field set to all ones with every other bit clear.
- R4: For every non-reset entry the block writes `core_sr` to address `core_r15`-4 and then `core_pc` to `core_r15`-8. It returns `new_sp` = `core_r15`-8 and `new_vbr` = `core_vbr`.
- R5: The handler word is read from `core_vbr` + 4*vector, and `new_pc` is that word. The vector is 9 for an address error, `irq_vec` for an interrupt, 4 for a general illegal opcode, 6 for an illegal delay-slot opcode, and `trap_vec` for a trap.
- R6: For an interrupt, `new_sr` is `core_sr` with SR[7:4] replaced by `irq_level`. For address errors, traps and illegal opcodes, `new_sr` equals `core_sr`.
- R7: `irq_req` is taken only in a cycle where `instr_done` is also high.
- R8: Requests present in the same cycle are served in this order: power-on, manual, address error, interrupt, general illegal, slot illegal, trap.
- R9: `busy` is high from the cycle after acceptance through the load cycle. Level requests seen only while busy are ignored. Reset edges and watchdog pulses that arrive while busy are remembered and served afterwards.
- R10: `mem_addr`, `mem_we` and `mem_wdata` stay stable while `mem_req` is high and `mem_ready` is low. An access completes in a cycle where both are high, and `mem_we` is never high without `mem_req`.
- R11: `load_valid` is a single-cycle pulse that ends each sequence. `new_pc`, `new_sp`, `new_vbr` and `new_sr` then hold until the next sequence completes.
- R12: After `rst`, `busy`, `mem_req` and `load_valid` are low and all four result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| pwr_rst_n | input | 1 | Power-on reset line; its rising edge starts a power-on entry |
| man_rst_n | input | 1 | Manual reset line; its rising edge starts a manual entry |
| wdt_pwr_ovf | input | 1 | Watchdog overflow pulse selecting a power-on entry |
| wdt_man_ovf | input | 1 | Watchdog overflow pulse selecting a manual entry |
| adr_err_req | input | 1 | Address error request (level) |
| irq_req | input | 1 | Interrupt request (level) |
| irq_level | input | 4 | Priority level of the pending interrupt |
| irq_vec | input | 8 | Vector number of the pending interrupt |
| instr_done | input | 1 | Current instruction has finished executing |
| gen_ill_req | input | 1 | Undefined opcode outside a delay slot |
| slot_ill_req | input | 1 | Undefined or PC-changing opcode in a delay slot |
| trap_req | input | 1 | Trap instruction executing |
| trap_vec | input | 8 | Vector number carried by the trap |
| core_pc | input | 32 | PC to save |
| core_sr | input | 32 | Status word to save |
| core_r15 | input | 32 | Current stack pointer |
| core_vbr | input | 32 | Current vector base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Sequence in progress |
| load_valid | output | 1 | New values are to be loaded by the core this cycle |
| new_pc | output | 32 | New program counter |
| new_sp | output | 32 | New stack pointer |
| new_vbr | output | 32 | New vector base |
| new_sr | output | 32 | New status word |

## Verification
The hardest situation to reach is a reset event landing while another entry is still on the bus. In that case the edge has to be remembered, not lost, and the level requests raised at the same moment have to be dropped. The stimulus slows the memory model to several wait states and starts a trap entry. Once `busy` is seen high, it pulses the manual watchdog line and holds an address error for two cycles. The bench then expects a manual entry right after the trap completes, and no further activity after that. Priority is reached by raising up to four requests in one cycle and releasing each one at the load cycle that serves it. For reset-versus-level priority, the address error is raised one cycle after the reset edge, because the edge needs one cycle to be latched.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN   = 32;
    localparam int VEC_W  = 8;
    localparam int LVL_W  = 4;
    localparam int WORD_B = XLEN / 8;
    localparam int NUM_CLS = 8;
    localparam int NUM_RST = 2;

    // Encoding order equals service priority (lower code wins).
    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_POR    = 3'd1,
        CLS_MRST   = 3'd2,
        CLS_ADRERR = 3'd3,
        CLS_IRQ    = 3'd4,
        CLS_GILL   = 3'd5,
        CLS_SILL   = 3'd6,
        CLS_TRAP   = 3'd7
    } exc_cls_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_SR,
        ST_PUSH_PC,
        ST_FETCH_VEC,
        ST_FETCH_PC,
        ST_FETCH_SP,
        ST_DONE
    } seq_st_e;

    typedef struct packed {
        exc_cls_e               cls;
        logic [VEC_W-1:0]       vec;
        logic [LVL_W-1:0]       lvl;
        logic [XLEN-1:0]        pc;
        logic [XLEN-1:0]        sr;
        logic [XLEN-1:0]        sp;
        logic [XLEN-1:0]        vbr;
    } exc_ctx_t;

    function automatic logic is_reset_cls(exc_cls_e c);
        return (c == CLS_POR) || (c == CLS_MRST);
    endfunction

    function automatic logic [XLEN-1:0] vec_offset(logic [VEC_W-1:0] v);
        return XLEN'(v) * XLEN'(WORD_B);
    endfunction

    function automatic logic [XLEN-1:0] put_mask(logic [XLEN-1:0] sr,
                                                 logic [LVL_W-1:0] lvl,
                                                 int lsb);
        logic [XLEN-1:0] r;
        r = sr;
        r[lsb +: LVL_W] = lvl;
        return r;
    endfunction

endpackage

// File: rtl/exc_event_latch.sv
module exc_event_latch
    import exc_entry_pkg::*;
#(
    parameter int N = NUM_RST
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_n,
    input  logic [N-1:0] wdt_ovf,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);

    for (genvar ch = 0; ch < N; ch++) begin : g_ch
        logic prev_q;
        logic pend_q;
        logic event_w;

        assign event_w = (pin_n[ch] & ~prev_q) | wdt_ovf[ch];

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b1;
                pend_q <= 1'b0;
            end else begin
                prev_q <= pin_n[ch];
                if (event_w) begin
                    pend_q <= 1'b1;
                end else if (clr[ch]) begin
                    pend_q <= 1'b0;
                end
            end
        end

        assign pend[ch] = pend_q;
    end

endmodule

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
    import exc_entry_pkg::*;
(
    input  logic [NUM_CLS-1:1] req,
    output exc_cls_e           grant
);

    always_comb begin
        grant = CLS_NONE;
        for (int i = NUM_CLS - 1; i >= 1; i--) begin
            if (req[i]) begin
                grant = exc_cls_e'(3'(i));
            end
        end
    end

endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] POR_BASE  = 32'h0000_0000,
    parameter logic [XLEN-1:0] MRST_BASE = 32'h0000_0008,
    parameter int              MASK_LSB  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  exc_ctx_t        start_ctx,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_ready,
    output logic            busy,
    output logic            load_valid,
    output logic [XLEN-1:0] new_pc,
    output logic [XLEN-1:0] new_sp,
    output logic [XLEN-1:0] new_vbr,
    output logic [XLEN-1:0] new_sr,
    output exc_cls_e        act_cls
);

    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_B);

    seq_st_e         st_q;
    exc_ctx_t        ctx_q;
    logic [XLEN-1:0] pc_tmp_q;
    logic [XLEN-1:0] pc_q, sp_q, vbr_q, sr_q;

    logic [XLEN-1:0] sp_hi, sp_lo, rst_base, vec_addr;

    assign sp_hi    = ctx_q.sp - STEP;
    assign sp_lo    = ctx_q.sp - (STEP + STEP);
    assign rst_base = (ctx_q.cls == CLS_POR) ? POR_BASE : MRST_BASE;
    assign vec_addr = ctx_q.vbr + vec_offset(ctx_q.vec);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st_q)
            ST_PUSH_SR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_hi;
                mem_wdata = ctx_q.sr;
            end
            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_lo;
                mem_wdata = ctx_q.pc;
            end
            ST_FETCH_VEC: begin
                mem_req  = 1'b1;
                mem_addr = vec_addr;
            end
            ST_FETCH_PC: begin
                mem_req  = 1'b1;
                mem_addr = rst_base;
            end
            ST_FETCH_SP: begin
                mem_req  = 1'b1;
                mem_addr = rst_base + STEP;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            ctx_q    <= '0;
            pc_tmp_q <= '0;
            pc_q     <= '0;
            sp_q     <= '0;
            vbr_q    <= '0;
            sr_q     <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        ctx_q <= start_ctx;
                        st_q  <= is_reset_cls(start_ctx.cls) ? ST_FETCH_PC : ST_PUSH_SR;
                    end
                end
                ST_PUSH_SR: begin
                    if (mem_ready) st_q <= ST_PUSH_PC;
                end
                ST_PUSH_PC: begin
                    if (mem_ready) st_q <= ST_FETCH_VEC;
                end
                ST_FETCH_VEC: begin
                    if (mem_ready) begin
                        pc_q  <= mem_rdata;
                        sp_q  <= sp_lo;
                        vbr_q <= ctx_q.vbr;
                        sr_q  <= (ctx_q.cls == CLS_IRQ)
                                 ? put_mask(ctx_q.sr, ctx_q.lvl, MASK_LSB)
                                 : ctx_q.sr;
                        st_q  <= ST_DONE;
                    end
                end
                ST_FETCH_PC: begin
                    if (mem_ready) begin
                        pc_tmp_q <= mem_rdata;
                        st_q     <= ST_FETCH_SP;
                    end
                end
                ST_FETCH_SP: begin
                    if (mem_ready) begin
                        pc_q  <= pc_tmp_q;
                        sp_q  <= mem_rdata;
                        vbr_q <= '0;
                        sr_q  <= put_mask('0, {LVL_W{1'b1}}, MASK_LSB);
                        st_q  <= ST_DONE;
                    end
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (st_q != ST_IDLE);
    assign load_valid = (st_q == ST_DONE);
    assign new_pc     = pc_q;
    assign new_sp     = sp_q;
    assign new_vbr    = vbr_q;
    assign new_sr     = sr_q;
    assign act_cls    = ctx_q.cls;

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0]  POR_BASE   = 32'h0000_0000,
    parameter logic [XLEN-1:0]  MRST_BASE  = 32'h0000_0008,
    parameter logic [VEC_W-1:0] ADRERR_VEC = 8'd9,
    parameter logic [VEC_W-1:0] GILL_VEC   = 8'd4,
    parameter logic [VEC_W-1:0] SILL_VEC   = 8'd6,
    parameter int               MASK_LSB   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_rst_n,
    input  logic             man_rst_n,
    input  logic             wdt_pwr_ovf,
    input  logic             wdt_man_ovf,
    input  logic             adr_err_req,
    input  logic             irq_req,
    input  logic [LVL_W-1:0] irq_level,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic             instr_done,
    input  logic             gen_ill_req,
    input  logic             slot_ill_req,
    input  logic             trap_req,
    input  logic [VEC_W-1:0] trap_vec,
    input  logic [XLEN-1:0]  core_pc,
    input  logic [XLEN-1:0]  core_sr,
    input  logic [XLEN-1:0]  core_r15,
    input  logic [XLEN-1:0]  core_vbr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    input  logic             mem_ready,
    output logic             busy,
    output logic             load_valid,
    output logic [XLEN-1:0]  new_pc,
    output logic [XLEN-1:0]  new_sp,
    output logic [XLEN-1:0]  new_vbr,
    output logic [XLEN-1:0]  new_sr
);

    logic [NUM_RST-1:0] rst_pins_n, wdt_ovf, pend, clr;
    logic [NUM_CLS-1:1] req;
    exc_cls_e           grant;
    exc_cls_e           act_cls;
    logic               start;
    exc_ctx_t           start_ctx;

    assign rst_pins_n = {man_rst_n, pwr_rst_n};
    assign wdt_ovf    = {wdt_man_ovf, wdt_pwr_ovf};

    exc_event_latch #(.N(NUM_RST)) u_evt (
        .clk     (clk),
        .rst     (rst),
        .pin_n   (rst_pins_n),
        .wdt_ovf (wdt_ovf),
        .clr     (clr),
        .pend    (pend)
    );

    // Bit index equals the class code.
    assign req = {trap_req, slot_ill_req, gen_ill_req, irq_req & instr_done,
                  adr_err_req, pend[1], pend[0]};

    exc_prio_arb u_arb (
        .req   (req),
        .grant (grant)
    );

    assign start = !busy && (grant != CLS_NONE);
    assign clr   = {start && (grant == CLS_MRST), start && (grant == CLS_POR)};

    always_comb begin
        start_ctx     = '0;
        start_ctx.cls = grant;
        start_ctx.lvl = irq_level;
        start_ctx.pc  = core_pc;
        start_ctx.sr  = core_sr;
        start_ctx.sp  = core_r15;
        start_ctx.vbr = core_vbr;
        case (grant)
            CLS_ADRERR: start_ctx.vec = ADRERR_VEC;
            CLS_IRQ:    start_ctx.vec = irq_vec;
            CLS_GILL:   start_ctx.vec = GILL_VEC;
            CLS_SILL:   start_ctx.vec = SILL_VEC;
            CLS_TRAP:   start_ctx.vec = trap_vec;
            default:    start_ctx.vec = '0;
        endcase
    end

    exc_seq_fsm #(
        .POR_BASE  (POR_BASE),
        .MRST_BASE (MRST_BASE),
        .MASK_LSB  (MASK_LSB)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_ctx  (start_ctx),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready),
        .busy       (busy),
        .load_valid (load_valid),
        .new_pc     (new_pc),
        .new_sp     (new_sp),
        .new_vbr    (new_vbr),
        .new_sr     (new_sr),
        .act_cls    (act_cls)
    );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int MASK_LSB = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            load_valid,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ready,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic [XLEN-1:0] new_vbr,
    input logic [XLEN-1:0] new_sr,
    input exc_cls_e        act_cls
);

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R10
    write_has_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);

    // R11
    load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        load_valid |=> !load_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !load_valid));

    // R3
    reset_result_chk: assert property (@(posedge clk) disable iff (rst)
        (load_valid && (act_cls == CLS_POR || act_cls == CLS_MRST)) |->
            (new_vbr == '0 && new_sr[MASK_LSB +: LVL_W] == {LVL_W{1'b1}}));

endmodule

bind exc_entry_seq exc_entry_chk #(.MASK_LSB(MASK_LSB)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .load_valid (load_valid),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .new_vbr    (new_vbr),
    .new_sr     (new_sr),
    .act_cls    (act_cls)
);

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;
    localparam logic [31:0] TAG = 32'hA500_0000;

    typedef struct packed {
        logic [2:0]  kind;   // 0 adr err, 1 irq, 2 gen ill, 3 slot ill, 4 trap
        logic [3:0]  lvl;
        logic [7:0]  vec;
        logic [31:0] pc;
        logic [31:0] sr;
        logic [31:0] r15;
        logic [31:0] vbr;
        logic [31:0] vaddr;
        logic [31:0] exp_sr;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t TBL [NV] = '{
        '{3'd0, 4'h0, 8'd0,  32'h0000_1234, 32'h0000_0030, 32'h0000_00F0, 32'h0000_0040, 32'h0000_0064, 32'h0000_0030},
        '{3'd1, 4'hA, 8'd20, 32'h0000_2222, 32'h0000_0301, 32'h0000_00D0, 32'h0000_0020, 32'h0000_0070, 32'h0000_03A1},
        '{3'd2, 4'h0, 8'd0,  32'h0000_3330, 32'h0000_00E0, 32'h0000_00C0, 32'h0000_0040, 32'h0000_0050, 32'h0000_00E0},
        '{3'd3, 4'h0, 8'd0,  32'h0000_4440, 32'h0000_0055, 32'h0000_00B0, 32'h0000_0040, 32'h0000_0058, 32'h0000_0055},
        '{3'd4, 4'h0, 8'd12, 32'h0000_5550, 32'h0000_01F0, 32'h0000_00F8, 32'h0000_0020, 32'h0000_0050, 32'h0000_01F0},
        '{3'd1, 4'h3, 8'd2,  32'h0000_6660, 32'hFFFF_FFFF, 32'h0000_0090, 32'h0000_0040, 32'h0000_0048, 32'hFFFF_FF3F}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_rst_n = 1'b1, man_rst_n = 1'b1;
    logic        wdt_pwr_ovf = 1'b0, wdt_man_ovf = 1'b0;
    logic        adr_err_req = 1'b0, irq_req = 1'b0, instr_done = 1'b0;
    logic        gen_ill_req = 1'b0, slot_ill_req = 1'b0, trap_req = 1'b0;
    logic [3:0]  irq_level = '0;
    logic [7:0]  irq_vec = '0, trap_vec = '0;
    logic [31:0] core_pc = '0, core_sr = '0, core_r15 = '0, core_vbr = '0;
    logic        mem_req, mem_we, busy, load_valid;
    logic [31:0] mem_addr, mem_wdata, new_pc, new_sp, new_vbr, new_sr;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    logic [31:0] mem [64];
    int          lat = 0;
    int          wcnt = 0;
    int          n_checks = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    exc_entry_seq dut_i (
        .clk(clk), .rst(rst), .pwr_rst_n(pwr_rst_n), .man_rst_n(man_rst_n),
        .wdt_pwr_ovf(wdt_pwr_ovf), .wdt_man_ovf(wdt_man_ovf),
        .adr_err_req(adr_err_req), .irq_req(irq_req), .irq_level(irq_level),
        .irq_vec(irq_vec), .instr_done(instr_done), .gen_ill_req(gen_ill_req),
        .slot_ill_req(slot_ill_req), .trap_req(trap_req), .trap_vec(trap_vec),
        .core_pc(core_pc), .core_sr(core_sr), .core_r15(core_r15), .core_vbr(core_vbr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy), .load_valid(load_valid),
        .new_pc(new_pc), .new_sp(new_sp), .new_vbr(new_vbr), .new_sr(new_sr)
    );

    // Memory model: word i holds TAG | (4*i) until written.
    initial begin
        for (int i = 0; i < 64; i++) mem[i] = TAG | 32'(i * 4);
    end

    always @(posedge clk) begin
        if (rst) begin
            mem_ready <= 1'b0;
            wcnt      <= 0;
        end else if (mem_req && !mem_ready) begin
            if (wcnt >= lat) begin
                mem_ready <= 1'b1;
                wcnt      <= 0;
                if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[7:2]];
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ready <= 1'b0;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_busy(input string req);
        int n = 0;
        while (!busy && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(req, 32'(busy), 32'd1);
    endtask

    task automatic wait_load(input string req);
        int n = 0;
        while (!load_valid && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk(req, 32'(load_valid), 32'd1);
    endtask

    task automatic set_core(input logic [31:0] pc, input logic [31:0] sr,
                            input logic [31:0] r15, input logic [31:0] vbr);
        core_pc  = pc;
        core_sr  = sr;
        core_r15 = r15;
        core_vbr = vbr;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        chk("R12 busy", 32'(busy), 0);
        chk("R12 mem_req", 32'(mem_req), 0);
        chk("R12 load_valid", 32'(load_valid), 0);
        chk("R12 new_pc", new_pc, 0);
        chk("R12 new_sr", new_sr, 0);

        set_core(32'h0000_7770, 32'h0000_0123, 32'h0000_00F0, 32'h0000_0040);

        // R1: power-on via pin edge
        pwr_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        pwr_rst_n = 1'b1;
        wait_load("R1 load");
        chk("R1 pc", new_pc, TAG | 32'h0);
        chk("R1 sp", new_sp, TAG | 32'h4);
        chk("R3 vbr", new_vbr, 32'h0);
        chk("R3 sr", new_sr, 32'h0000_00F0);
        @(negedge clk);
        chk("R11 pulse", 32'(load_valid), 0);
        chk("R11 hold", new_pc, TAG | 32'h0);

        // R2: manual via pin edge
        lat = 2;
        man_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        man_rst_n = 1'b1;
        wait_load("R2 load");
        chk("R2 pc", new_pc, TAG | 32'h8);
        chk("R2 sp", new_sp, TAG | 32'hC);
        chk("R3 sr", new_sr, 32'h0000_00F0);

        // R1 / R2: watchdog pulses
        @(negedge clk);
        wdt_pwr_ovf = 1'b1;
        @(negedge clk);
        wdt_pwr_ovf = 1'b0;
        wait_load("R1 wdt load");
        chk("R1 wdt pc", new_pc, TAG | 32'h0);
        @(negedge clk);
        wdt_man_ovf = 1'b1;
        @(negedge clk);
        wdt_man_ovf = 1'b0;
        wait_load("R2 wdt load");
        chk("R2 wdt sp", new_sp, TAG | 32'hC);
        @(negedge clk);

        // R4/R5/R6: table walk
        for (int k = 0; k < NV; k++) begin
            lat = k % 3;
            @(negedge clk);
            set_core(TBL[k].pc, TBL[k].sr, TBL[k].r15, TBL[k].vbr);
            irq_level = TBL[k].lvl;
            irq_vec   = TBL[k].vec;
            trap_vec  = TBL[k].vec;
            case (TBL[k].kind)
                3'd0: adr_err_req = 1'b1;
                3'd1: begin irq_req = 1'b1; instr_done = 1'b1; end
                3'd2: gen_ill_req = 1'b1;
                3'd3: slot_ill_req = 1'b1;
                default: trap_req = 1'b1;
            endcase
            @(negedge clk);
            wait_busy("R9 busy");
            adr_err_req = 0; irq_req = 0; instr_done = 0;
            gen_ill_req = 0; slot_ill_req = 0; trap_req = 0;
            wait_load("R11 load");
            chk("R5 handler", new_pc, TAG | TBL[k].vaddr);
            chk("R4 sp", new_sp, TBL[k].r15 - 32'd8);
            chk("R4 vbr", new_vbr, TBL[k].vbr);
            chk("R6 sr", new_sr, TBL[k].exp_sr);
            chk("R4 saved sr", mem[(TBL[k].r15 - 32'd4) >> 2], TBL[k].sr);
            chk("R4 saved pc", mem[(TBL[k].r15 - 32'd8) >> 2], TBL[k].pc);
            @(negedge clk);
        end

        // R7: interrupt waits for instruction completion
        lat = 0;
        set_core(32'h0000_8880, 32'h0000_0000, 32'h0000_00F0, 32'h0000_0040);
        irq_req = 1'b1; irq_level = 4'h5; irq_vec = 8'd3;
        repeat (8) @(negedge clk);
        chk("R7 no accept", 32'(busy), 0);
        chk("R7 no access", 32'(mem_req), 0);
        instr_done = 1'b1;
        @(negedge clk);
        wait_busy("R7 busy");
        irq_req = 1'b0; instr_done = 1'b0;
        wait_load("R7 load");
        chk("R7 sr", new_sr, 32'h0000_0050);
        chk("R7 handler", new_pc, TAG | 32'h4C);
        @(negedge clk);

        // R8: level priority chain
        irq_level = 4'h7; irq_vec = 8'd1; trap_vec = 8'd13;
        adr_err_req = 1'b1; irq_req = 1'b1; instr_done = 1'b1;
        gen_ill_req = 1'b1; trap_req = 1'b1;
        wait_load("R8 load1");
        adr_err_req = 1'b0;
        chk("R8 adr err first", new_pc, TAG | 32'h64);
        @(negedge clk);
        wait_load("R8 load2");
        irq_req = 1'b0; instr_done = 1'b0;
        chk("R8 irq second", new_sr, 32'h0000_0070);
        @(negedge clk);
        wait_load("R8 load3");
        gen_ill_req = 1'b0;
        chk("R8 gen ill third", new_pc, TAG | 32'h50);
        @(negedge clk);
        wait_load("R8 load4");
        trap_req = 1'b0;
        chk("R8 trap last", new_pc, TAG | 32'h74);
        @(negedge clk);

        // R8: reset edge beats address error
        pwr_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        pwr_rst_n = 1'b1;
        @(negedge clk);
        adr_err_req = 1'b1;
        wait_load("R8 por load");
        chk("R8 por first", new_vbr, 32'h0);
        chk("R8 por pc", new_pc, TAG | 32'h0);
        @(negedge clk);
        wait_load("R8 adr load");
        adr_err_req = 1'b0;
        chk("R8 adr after por", new_pc, TAG | 32'h64);
        @(negedge clk);

        // R9: events during busy
        lat = 3;
        trap_vec = 8'd12;
        set_core(32'h0000_9990, 32'h0000_0011, 32'h0000_00F0, 32'h0000_0020);
        trap_req = 1'b1;
        @(negedge clk);
        wait_busy("R9 trap busy");
        trap_req = 1'b0;
        @(negedge clk);
        wdt_man_ovf = 1'b1;
        adr_err_req = 1'b1;
        @(negedge clk);
        wdt_man_ovf = 1'b0;
        @(negedge clk);
        adr_err_req = 1'b0;
        wait_load("R9 trap load");
        chk("R9 trap pc", new_pc, TAG | 32'h50);
        @(negedge clk);
        wait_load("R9 latched manual");
        chk("R9 manual pc", new_pc, TAG | 32'h8);
        repeat (12) @(negedge clk);
        chk("R9 adr err dropped", 32'(busy), 0);
        chk("R9 outputs held", new_pc, TAG | 32'h8);

        summary();
        $finish;
    end

endmodule